// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block sits between a simple request port and an asynchronous-style DRAM whose row and column addresses travel over one shared address bus. For each accepted request it opens a row by placing the row on the bus and pulling the row strobe low. It then issues one or more column strobes, each with a column on the same bus, and closes the row. Every delay is a parameter counted in clock cycles: row-to-column delay, column read latency and precharge gap.

There are three access modes. A single access opens a row, makes one column access and closes the row. A burst access takes only the first column from the requester and produces the following columns with an internal counter. The counter wraps inside the burst-aligned block. A page access keeps the row open across a requester-chosen number of column strobes, and the requester supplies every column through a beat handshake. Write data goes to the pads through an output-enable pair, and read data is captured from the pad input. A separate refresh block gets the memory through a request/grant pair, and that grant is only given with the row closed.

Top module: `dram_seq`

## Requirements
- R1: The row is on `mem_addr` (low ROW_W bits) in the cycle `mem_ras_n` falls. The column is on `mem_addr` (low COL_W bits) in every cycle `mem_cas_n` falls.
- R2: The first column strobe of an access falls exactly ROW_LAT cycles after the row strobe falls.
- R3: Mode 0 (and the spare code 3) makes exactly one column access at `req_col`, then the row strobe rises.
- R4: Mode 1 makes BURST_LEN column accesses. The low log2(BURST_LEN) column bits count up by one and wrap to zero, and the upper column bits stay at the value taken from `req_col`.
- R5: Mode 2 holds the row strobe low across `req_len` column accesses (a length of 0 counts as 1). The first column is `req_col`, and each later one is the `beat_col` presented when `beat_take` is high.
- R6: A read column strobe stays low for COL_LAT cycles. `mem_dq_in` is captured on the last of them, and `rd_valid` pulses for one cycle with that value on `rd_data` in the next cycle.
- R7: `mem_dq_oe` is high only while a write column strobe is low, and the write data is on `mem_dq_out` then. It is low in every other cycle, including all read cycles.
- R8: The row strobe stays high for at least PRE_LAT cycles between closing a row and opening the next one.
- R9: `req_ready` is high only when the sequencer is idle with the row closed and `ref_req` is low. A request is accepted on a cycle with `req_valid` and `req_ready` both high.
- R10: `ref_gnt` is only high with both strobes high. A `ref_req` raised during an access does not cut the access short: all its beats, including read returns, complete before the grant.
- R11: Out of reset both strobes are high, `mem_dq_oe` and `rd_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 0 single, 1 burst, 2 page, 3 single |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | First column |
| req_len | input | LEN_W | Page-mode beat count (0 means 1) |
| req_wdata | input | DATA_W | Write data of the first beat |
| beat_take | output | 1 | `beat_col`/`beat_wdata` consumed at this edge |
| beat_col | input | COL_W | Column of the next page beat |
| beat_wdata | input | DATA_W | Write data of the next beat |
| rd_valid | output | 1 | Read beat returned |
| rd_data | output | DATA_W | Read beat data |
| ref_req | input | 1 | Refresh block asks for the memory |
| ref_gnt | output | 1 | Memory handed to the refresh block |
| mem_addr | output | max(ROW_W,COL_W) | Shared row/column address bus |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_dq_out | output | DATA_W | Data toward the pads |
| mem_dq_oe | output | 1 | Pad output enable; low releases the bus |
| mem_dq_in | input | DATA_W | Data from the pads |

## Verification
The bench's memory model drives a poison value until the column strobe has been low for COL_LAT cycles. A design that captures read data one cycle early returns that poison instead of the stored byte. A burst that starts near the top of its aligned block checks wrapping: a counter that carries into the upper column bits writes outside the block, and later page reads of the block find the wrong bytes. A refresh request is raised while a burst is in progress, so a design that grants early shows the grant with the row strobe low or with read beats still pending. The bench also checks row-to-column spacing, precharge gaps and per-row beat counts on the strobes, which catches an off-by-one in any of the delay counters.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
   typedef enum logic [1:0] {
      MD_SINGLE = 2'd0,
      MD_BURST  = 2'd1,
      MD_PAGE   = 2'd2,
      MD_SPARE  = 2'd3
   } dseq_mode_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ROW,
      S_COL,
      S_GAP,
      S_PRE,
      S_REF
   } dseq_state_e;
endpackage

// File: rtl/dseq_timer.sv
module dseq_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/dseq_colgen.sv
module dseq_colgen #(
   parameter int COL_W     = 5,
   parameter int BURST_LEN = 4
) (
   input  logic             is_burst,
   input  logic [COL_W-1:0] cur_col,
   input  logic [COL_W-1:0] page_col,
   output logic [COL_W-1:0] nxt_col
);
   localparam int BL_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

   generate
      if (BURST_LEN > 1) begin : g_wrap
         logic [BL_W-1:0] low_inc;
         assign low_inc = cur_col[BL_W-1:0] + BL_W'(1);
         if (BL_W < COL_W) begin : g_hi
            assign nxt_col = is_burst ? {cur_col[COL_W-1:BL_W], low_inc} : page_col;
         end else begin : g_full
            assign nxt_col = is_burst ? low_inc : page_col;
         end
      end else begin : g_nowrap
         logic unused_cur;
         assign unused_cur = ^{cur_col, is_burst};
         assign nxt_col    = page_col;
      end
   endgenerate
endmodule

// File: rtl/dseq_rdcap.sv
module dseq_rdcap #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [DATA_W-1:0] din,
   output logic              valid,
   output logic [DATA_W-1:0] dout
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else begin
         valid <= cap;
         if (cap) dout <= din;
      end
   end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
   import dseq_pkg::*;
#(
   parameter int ROW_W     = 6,
   parameter int COL_W     = 5,
   parameter int DATA_W    = 8,
   parameter int LEN_W     = 3,
   parameter int BURST_LEN = 4,
   parameter int ROW_LAT   = 3,
   parameter int COL_LAT   = 2,
   parameter int PRE_LAT   = 2,
   localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [1:0]        req_mode,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              beat_take,
   input  logic [COL_W-1:0]  beat_col,
   input  logic [DATA_W-1:0] beat_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ref_req,
   output logic              ref_gnt,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ras_n,
   output logic              mem_cas_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int MAXL    = (ROW_LAT > COL_LAT) ? ((ROW_LAT > PRE_LAT) ? ROW_LAT : PRE_LAT)
                                                : ((COL_LAT > PRE_LAT) ? COL_LAT : PRE_LAT);
   localparam int CNT_W   = $clog2(MAXL + 2);
   localparam int BLC_W   = $clog2(BURST_LEN + 1);
   localparam int LEFT_W  = (LEN_W > BLC_W) ? LEN_W : BLC_W;
   localparam int BL_BITS = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 0;

   generate
      if (ROW_LAT < 1 || COL_LAT < 1 || PRE_LAT < 1) begin : g_bad_lat
         $error("dram_seq: every latency must be at least one cycle");
      end
      if ((BURST_LEN & (BURST_LEN - 1)) != 0 || BURST_LEN < 1) begin : g_bad_bl
         $error("dram_seq: BURST_LEN must be a power of two");
      end
      if (BL_BITS > COL_W) begin : g_bad_blw
         $error("dram_seq: burst block wider than the column");
      end
   endgenerate

   dseq_state_e       st_q, st_d;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q, col_d, nxt_col;
   logic [DATA_W-1:0] wdat_q, wdat_d;
   logic [LEFT_W-1:0] left_q, left_d, left_init;
   logic              wr_q, burst_q;
   logic              accept, cap;
   logic              t_load, t_done;
   logic [CNT_W-1:0]  t_val, col_wait;

   dseq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
   );

   dseq_colgen #(.COL_W(COL_W), .BURST_LEN(BURST_LEN)) u_colgen (
      .is_burst(burst_q), .cur_col(col_q), .page_col(beat_col), .nxt_col(nxt_col)
   );

   dseq_rdcap #(.DATA_W(DATA_W)) u_rdcap (
      .clk(clk), .rst_n(rst_n), .cap(cap), .din(mem_dq_in), .valid(rd_valid), .dout(rd_data)
   );

   assign col_wait = wr_q ? '0 : CNT_W'(COL_LAT - 1);

   always_comb begin
      case (dseq_mode_e'(req_mode))
         MD_BURST: left_init = LEFT_W'(BURST_LEN - 1);
         MD_PAGE:  left_init = (req_len == '0) ? '0 : LEFT_W'(req_len) - LEFT_W'(1);
         default:  left_init = '0;
      endcase
   end

   always_comb begin
      st_d   = st_q;
      t_load = 1'b0;
      t_val  = '0;
      left_d = left_q;
      col_d  = col_q;
      wdat_d = wdat_q;
      accept = 1'b0;
      cap    = 1'b0;
      unique case (st_q)
         S_IDLE: begin
            if (ref_req) begin
               st_d = S_REF;
            end else if (req_valid) begin
               accept = 1'b1;
               st_d   = S_ROW;
               t_load = 1'b1;
               t_val  = CNT_W'(ROW_LAT - 1);
            end
         end
         S_ROW: begin
            if (t_done) begin
               st_d   = S_COL;
               t_load = 1'b1;
               t_val  = col_wait;
            end
         end
         S_COL: begin
            if (t_done) begin
               st_d = S_GAP;
               cap  = !wr_q;
            end
         end
         S_GAP: begin
            if (left_q != '0) begin
               st_d   = S_COL;
               left_d = left_q - LEFT_W'(1);
               col_d  = nxt_col;
               wdat_d = beat_wdata;
               t_load = 1'b1;
               t_val  = col_wait;
            end else begin
               st_d   = S_PRE;
               t_load = 1'b1;
               t_val  = CNT_W'(PRE_LAT - 1);
            end
         end
         S_PRE: begin
            if (t_done) st_d = S_IDLE;
         end
         S_REF: begin
            if (!ref_req) begin
               st_d   = S_PRE;
               t_load = 1'b1;
               t_val  = CNT_W'(PRE_LAT - 1);
            end
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         row_q   <= '0;
         col_q   <= '0;
         wdat_q  <= '0;
         left_q  <= '0;
         wr_q    <= 1'b0;
         burst_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            row_q   <= req_row;
            col_q   <= req_col;
            wdat_q  <= req_wdata;
            left_q  <= left_init;
            wr_q    <= req_write;
            burst_q <= (dseq_mode_e'(req_mode) == MD_BURST);
         end else begin
            col_q  <= col_d;
            wdat_q <= wdat_d;
            left_q <= left_d;
         end
      end
   end

   assign mem_ras_n  = !(st_q == S_ROW || st_q == S_COL || st_q == S_GAP);
   assign mem_cas_n  = (st_q != S_COL);
   assign mem_addr   = (st_q == S_COL) ? ADDR_W'(col_q) : ADDR_W'(row_q);
   assign mem_dq_out = wdat_q;
   assign mem_dq_oe  = (st_q == S_COL) && wr_q;
   assign req_ready  = (st_q == S_IDLE) && !ref_req;
   assign ref_gnt    = (st_q == S_REF);
   assign beat_take  = (st_q == S_GAP) && (left_q != '0);

   // Timing watch counters for the checks below
   logic [CNT_W-1:0] hi_cnt, lo_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_cnt <= CNT_W'(PRE_LAT + 1);
         lo_cnt <= '0;
      end else begin
         if (!mem_ras_n)                          hi_cnt <= '0;
         else if (hi_cnt != CNT_W'(PRE_LAT + 1))  hi_cnt <= hi_cnt + CNT_W'(1);
         if (mem_ras_n)                           lo_cnt <= '0;
         else if (lo_cnt != CNT_W'(ROW_LAT))      lo_cnt <= lo_cnt + CNT_W'(1);
      end
   end

   AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ras_n) |-> hi_cnt >= CNT_W'(PRE_LAT)); // R8
   AST_ROW_TO_COL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_cas_n) |-> lo_cnt == CNT_W'(ROW_LAT) && !mem_ras_n); // R2
   AST_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> !mem_cas_n && !mem_ras_n); // R7
   AST_GNT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      ref_gnt |-> mem_ras_n && mem_cas_n && !rd_valid); // R10
   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> mem_ras_n && !ref_req); // R9
   AST_RDV_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!mem_cas_n && !mem_dq_oe)); // R6
   generate
      if (BURST_LEN > 1 && BL_BITS < COL_W) begin : g_wrap_chk
         AST_BURST_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(mem_cas_n) && burst_q && !$past(accept, 2) && $past(st_q) == S_GAP)
            |-> mem_addr[COL_W-1:BL_BITS] == $past(col_q[COL_W-1:BL_BITS])); // R4
      end
   endgenerate
endmodule

// File: tb/dram_seq_tb.sv
module dram_seq_tb;
   localparam int CLK_T  = 10;
   localparam int ROW_W  = 6;
   localparam int COL_W  = 5;
   localparam int DATA_W = 8;
   localparam int LEN_W  = 3;
   localparam int BL     = 4;
   localparam int RL     = 3;
   localparam int CL     = 2;
   localparam int PL     = 2;
   localparam int AW     = 6;
   localparam int NLOC   = 1 << (ROW_W + COL_W);

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_write = 0, ref_req = 0;
   logic [1:0] req_mode = 0;
   logic [ROW_W-1:0] req_row = 0;
   logic [COL_W-1:0] req_col = 0;
   logic [LEN_W-1:0] req_len = 0;
   logic [DATA_W-1:0] req_wdata = 0;
   logic [COL_W-1:0] pc [0:7];
   logic [DATA_W-1:0] wd [0:7];
   int bi = 1;
   logic req_ready, beat_take, rd_valid, ref_gnt, mem_ras_n, mem_cas_n, mem_dq_oe;
   logic [DATA_W-1:0] rd_data, mem_dq_out, mem_dq_in;
   logic [AW-1:0] mem_addr;
   logic [COL_W-1:0] beat_col;
   logic [DATA_W-1:0] beat_wdata;

   assign beat_col   = pc[bi];
   assign beat_wdata = wd[bi];

   int n_chk = 0, n_err = 0, cyc = 0, acc_seq = 0;
   logic [DATA_W-1:0] shadow [0:NLOC-1];
   logic [DATA_W-1:0] mem [0:NLOC-1];
   logic [ROW_W-1:0] rowq [$];
   logic [COL_W-1:0] colq [$];
   int beatq [$];
   logic [DATA_W-1:0] rdq [$];

   always #(CLK_T/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dram_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
              .BURST_LEN(BL), .ROW_LAT(RL), .COL_LAT(CL), .PRE_LAT(PL)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_mode(req_mode), .req_row(req_row), .req_col(req_col),
      .req_len(req_len), .req_wdata(req_wdata), .beat_take(beat_take), .beat_col(beat_col),
      .beat_wdata(beat_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req),
      .ref_gnt(ref_gnt), .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // Beat feeder: advances one entry after each consumed beat
   int seen_seq = 0;
   bit take_seen = 0;
   initial forever begin
      @(negedge clk);
      if (acc_seq != seen_seq) begin
         seen_seq = acc_seq; bi = 1; take_seen = 0;
      end else begin
         if (take_seen && bi < 7) bi = bi + 1;
         take_seen = beat_take;
      end
   end

   // Memory model and protocol monitor / scoreboard
   bit pr_ras = 1, pr_cas = 1, cur_wr = 0;
   int ras_fall = 0, ras_rise = -100, cas_fall = 0, beats = 0;
   logic [ROW_W-1:0] cur_row = 0;
   int low_cnt = 0;
   initial begin
      for (int i = 0; i < NLOC; i++) mem[i] = DATA_W'(i) ^ 8'h3C;
      mem_dq_in = 8'hEE;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (pr_ras && !mem_ras_n) begin
               logic [ROW_W-1:0] er;
               er = rowq.size() ? rowq.pop_front() : '1;
               chk(mem_addr[ROW_W-1:0] == er, "R1 row", mem_addr, er);
               chk(cyc - ras_rise >= PL, "R8 precharge", cyc - ras_rise, PL);
               cur_row = mem_addr[ROW_W-1:0]; ras_fall = cyc; beats = 0;
            end
            if (!pr_ras && mem_ras_n) begin
               int eb;
               eb = beatq.size() ? beatq.pop_front() : -1;
               chk(beats == eb, "R3/R5 beats per row", beats, eb);
               ras_rise = cyc;
            end
            if (pr_cas && !mem_cas_n) begin
               logic [COL_W-1:0] ec;
               ec = colq.size() ? colq.pop_front() : '1;
               chk(mem_addr[COL_W-1:0] == ec, "R1/R4/R5 column", mem_addr, ec);
               if (beats == 0) chk(cyc - ras_fall == RL, "R2 row to column", cyc - ras_fall, RL);
               beats++; cas_fall = cyc; cur_wr = mem_dq_oe; low_cnt = 0;
            end
            if (!pr_cas && mem_cas_n)
               chk(cyc - cas_fall == (cur_wr ? 1 : CL), "R6 strobe width", cyc - cas_fall, cur_wr ? 1 : CL);
            if (mem_dq_oe && mem_cas_n) chk(0, "R7 oe without strobe", 1, 0);
            if (!mem_cas_n && mem_dq_oe) mem[{cur_row, mem_addr[COL_W-1:0]}] = mem_dq_out;
            if (!mem_cas_n && !mem_dq_oe) begin
               low_cnt++;
               mem_dq_in = (low_cnt >= CL) ? mem[{cur_row, mem_addr[COL_W-1:0]}] : 8'hEE;
            end else mem_dq_in = 8'hEE;
            if (ref_gnt && (!mem_ras_n || !mem_cas_n)) chk(0, "R10 grant with row open", 1, 0);
            if (req_ready && (ref_req || !mem_ras_n)) chk(0, "R9 ready outside idle", 1, 0);
            if (rd_valid) begin
               logic [DATA_W-1:0] ed;
               ed = rdq.size() ? rdq.pop_front() : 8'hFF;
               chk(rd_data == ed, "R6 read data", rd_data, ed);
            end
            pr_ras = mem_ras_n; pr_cas = mem_cas_n;
         end
      end
   end

   // Driver: fills pc/wd first, pushes expectations, then handshakes
   task automatic access(input bit wr, input logic [1:0] md, input logic [ROW_W-1:0] row,
                         input logic [COL_W-1:0] col, input int len, input logic [DATA_W-1:0] dbase);
      int nb;
      if (md == 2'd1) nb = BL; else if (md == 2'd2) nb = (len == 0) ? 1 : len; else nb = 1;
      for (int k = 0; k < 8; k++) wd[k] = dbase + DATA_W'(k);
      if (md == 2'd1) for (int k = 0; k < BL; k++) pc[k] = {col[COL_W-1:2], col[1:0] + 2'(k)};
      else if (md != 2'd2) pc[0] = col;
      rowq.push_back(row); beatq.push_back(nb);
      for (int k = 0; k < nb; k++) begin
         colq.push_back(pc[k]);
         if (wr) shadow[{row, pc[k]}] = wd[k];
         else rdq.push_back(shadow[{row, pc[k]}]);
      end
      acc_seq++;
      repeat (2) @(negedge clk);
      req_write = wr; req_mode = md; req_row = row; req_col = pc[0];
      req_len = LEN_W'(len); req_wdata = wd[0]; req_valid = 1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic drain();
      int t = 0;
      while ((rdq.size() != 0 || colq.size() != 0 || !mem_ras_n) && t < 200) begin
         @(negedge clk); t++;
      end
      repeat (PL + 3) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < NLOC; i++) shadow[i] = DATA_W'(i) ^ 8'h3C;
      for (int k = 0; k < 8; k++) begin pc[k] = 0; wd[k] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk(mem_ras_n && mem_cas_n, "R11 strobes idle", {mem_ras_n, mem_cas_n}, 3);
      chk(!mem_dq_oe && !rd_valid, "R11 outputs quiet", {mem_dq_oe, rd_valid}, 0);
      chk(req_ready, "R11 ready", req_ready, 1);

      // R3 single write then read, R7 write path
      access(1, 2'd0, 6'd2, 5'd3, 0, 8'hA5); drain();
      access(0, 2'd0, 6'd2, 5'd3, 0, 8'h00); drain();
      // R4 burst write near top of aligned block: columns 6,7,4,5
      access(1, 2'd1, 6'd3, 5'd6, 0, 8'h40); drain();
      // R5 page read of the whole block
      pc[0] = 5'd4; pc[1] = 5'd5; pc[2] = 5'd6; pc[3] = 5'd7; pc[4] = 5'd8;
      access(0, 2'd2, 6'd3, 5'd4, 5, 8'h00); drain();
      // R4 burst read starting at last column of block
      access(0, 2'd1, 6'd3, 5'd7, 0, 8'h00); drain();
      // R5 page write to scattered columns, then reads incl. spare mode code 3
      pc[0] = 5'd1; pc[1] = 5'd17; pc[2] = 5'd30;
      access(1, 2'd2, 6'd9, 5'd1, 3, 8'h10); drain();
      access(0, 2'd3, 6'd9, 5'd17, 0, 8'h00); drain();
      pc[0] = 5'd30; pc[1] = 5'd2; pc[2] = 5'd1;
      access(0, 2'd2, 6'd9, 5'd30, 3, 8'h00); drain();
      // R5 page length 0 counts as one beat
      pc[0] = 5'd31;
      access(0, 2'd2, 6'd63, 5'd31, 0, 8'h00); drain();
      // R10 refresh raised during a burst read
      access(0, 2'd1, 6'd3, 5'd5, 0, 8'h00);
      ref_req = 1;
      begin
         int t = 0;
         while (!ref_gnt && t < 100) begin @(negedge clk); t++; end
      end
      chk(ref_gnt, "R10 grant given", ref_gnt, 1);
      chk(rdq.size() == 0, "R10 access finished before grant", rdq.size(), 0);
      chk(!req_ready, "R9 no ready during refresh", req_ready, 0);
      repeat (4) @(negedge clk);
      ref_req = 0;
      // R8 access right after refresh observes the gap
      access(1, 2'd0, 6'd40, 5'd12, 0, 8'h77); drain();
      access(0, 2'd0, 6'd40, 5'd12, 0, 8'h00); drain();
      chk(rdq.size() == 0 && colq.size() == 0 && beatq.size() == 0, "R6 scoreboard drained",
          rdq.size() + colq.size() + beatq.size(), 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule